// File: doc/BRIEF.md
# Keyed Write-Protection Guard for a Control Register

This block keeps one 8-bit control register safe from stray stores by a program that has lost control. It sits on a simple memory-mapped bus with a single-cycle write port and a combinational read port. It decodes three addresses: a write-only command location that takes an unlock key, the guarded control register, and a status register.

The control register takes a new value only after a fixed four-step ritual. First the key A5h goes to the command location. Then the guarded register receives the wanted value, its bitwise inverse and the wanted value again. Only the last of these writes changes the register. Any write that breaks the ritual leaves the register alone, puts the sequencer back into its locked state and raises a protection-error flag. The flag stays raised until software clears it. The current register value and the flag are also driven straight out of the block so that the logic around it can use them.

Top module: `wrp_guard`

## Requirements
- R1: After reset the control register reads 00h, the status register reads 00h and prot_err_o is 0.
- R2: The write sequence key A5h to the command address (FFC0h), value V, ~V and V to the control address (default FFC1h) loads V into the control register on the fourth write, and no error is raised.
- R3: The second and third writes of a valid sequence leave the control register unchanged.
- R4: A write to the control register while the sequencer is locked leaves it unchanged and sets the error flag (status bit 0).
- R5: A command write of any value other than A5h sets the error flag and locks the sequencer, so a later value/inverse/value pattern without a new key does not update the register.
- R6: A third write that is not the bitwise inverse of the second sets the error flag, leaves the register unchanged and locks the sequencer.
- R7: A fourth write that differs from the second sets the error flag and leaves the register unchanged.
- R8: After a completed update the sequencer is locked again, so another update needs a new key.
- R9: The error flag is sticky. Writing 1 to status bit 0 keeps it, writing 0 clears it, and status bits 7..1 always read 0.
- R10: Reading the command address or an undecoded address returns 00h. Reading the control address returns the register value.
- R11: Writes to the status register or to undecoded addresses in the middle of a sequence neither break it nor raise an error.
- R12: A key write of A5h in the middle of a sequence restarts it from the value step without raising an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one write per asserted cycle |
| bus_waddr_i | input | 16 | Write address |
| bus_wdata_i | input | 8 | Write data |
| bus_raddr_i | input | 16 | Read address |
| bus_rdata_o | output | 8 | Read data, combinational from bus_raddr_i |
| ctrl_o | output | 8 | Current value of the guarded control register |
| prot_err_o | output | 1 | Sticky protection-error flag |

## Verification
A write is taken on the rising edge where bus_we_i is high. The control register, the error flag and the sequencer state all take their new values on that same edge, so every result is visible one edge after the stimulus. Read data is combinational and follows the read address in the same cycle. The bench drives each write on a falling edge and drops the strobe on the next falling edge. It samples ctrl_o, prot_err_o and read data only after that falling edge, which is half a cycle after the capturing rising edge. A read is sampled one time unit after the address is applied.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED  = 2'd0,
    ST_KEYED   = 2'd1,
    ST_GOT_VAL = 2'd2,
    ST_GOT_INV = 2'd3
  } wrp_state_e;

  typedef struct packed {
    logic cmd;
    logic ctrl;
    logic stat;
  } wrp_sel_t;

endpackage

// File: rtl/wrp_decode.sv
module wrp_decode
  import wrp_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  CMD_ADDR  = 16'hFFC0,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR = 16'hFFC1,
  parameter logic [ADDR_W-1:0]  STAT_ADDR = 16'hFFC2
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output wrp_sel_t          wr_sel_o,
  output wrp_sel_t          rd_sel_o
);

  always_comb begin
    wr_sel_o.cmd  = we_i && (waddr_i == CMD_ADDR);
    wr_sel_o.ctrl = we_i && (waddr_i == CTRL_ADDR);
    wr_sel_o.stat = we_i && (waddr_i == STAT_ADDR);
    rd_sel_o.cmd  = (raddr_i == CMD_ADDR);
    rd_sel_o.ctrl = (raddr_i == CTRL_ADDR);
    rd_sel_o.stat = (raddr_i == STAT_ADDR);
  end

endmodule

// File: rtl/wrp_seq.sv
module wrp_seq
  import wrp_pkg::*;
#(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY    = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              commit_o,
  output logic              viol_o
);

  wrp_state_e        state_q, state_d;
  logic [DATA_W-1:0] stash_q;
  logic              stash_en;

  always_comb begin
    state_d  = state_q;
    commit_o = 1'b0;
    viol_o   = 1'b0;
    stash_en = 1'b0;
    if (cmd_we_i) begin
      if (wdata_i == KEY) begin
        state_d = ST_KEYED;   // valid key restarts from any state
      end else begin
        viol_o  = 1'b1;
        state_d = ST_LOCKED;
      end
    end else if (ctrl_we_i) begin
      unique case (state_q)
        ST_LOCKED: viol_o = 1'b1;
        ST_KEYED: begin
          stash_en = 1'b1;
          state_d  = ST_GOT_VAL;
        end
        ST_GOT_VAL: begin
          if (wdata_i == ~stash_q) begin
            state_d = ST_GOT_INV;
          end else begin
            viol_o  = 1'b1;
            state_d = ST_LOCKED;
          end
        end
        ST_GOT_INV: begin
          if (wdata_i == stash_q) commit_o = 1'b1;
          else                    viol_o   = 1'b1;
          state_d = ST_LOCKED;
        end
        default: state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCKED;
      stash_q <= '0;
    end else begin
      state_q <= state_d;
      if (stash_en) stash_q <= wdata_i;
    end
  end

endmodule

// File: rtl/wrp_status.sv
module wrp_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic err_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               err_o <= 1'b0;
    else if (set_i)            err_o <= 1'b1;
    else if (wr_i && !wbit_i)  err_o <= 1'b0;  // write-0-to-clear only
  end

endmodule

// File: rtl/wrp_guard.sv
module wrp_guard
  import wrp_pkg::*;
#(
  parameter int unsigned            ADDR_W    = 16,
  parameter int unsigned            DATA_W    = 8,
  parameter logic [ADDR_W-1:0]      CMD_ADDR  = 16'hFFC0,
  parameter logic [ADDR_W-1:0]      CTRL_ADDR = 16'hFFC1,
  parameter logic [ADDR_W-1:0]      STAT_ADDR = 16'hFFC2,
  parameter logic [DATA_W-1:0]      KEY       = 8'hA5,
  parameter logic [DATA_W-1:0]      CTRL_RST  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_waddr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [ADDR_W-1:0] bus_raddr_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              prot_err_o
);

  localparam int unsigned PAD_W = DATA_W - 1;

  wrp_sel_t          wr_sel, rd_sel;
  logic              commit, viol;
  logic [DATA_W-1:0] ctrl_q;

  wrp_decode #(
    .ADDR_W    (ADDR_W),
    .CMD_ADDR  (CMD_ADDR),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_decode (
    .we_i     (bus_we_i),
    .waddr_i  (bus_waddr_i),
    .raddr_i  (bus_raddr_i),
    .wr_sel_o (wr_sel),
    .rd_sel_o (rd_sel)
  );

  wrp_seq #(
    .DATA_W (DATA_W),
    .KEY    (KEY)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (wr_sel.cmd),
    .ctrl_we_i (wr_sel.ctrl),
    .wdata_i   (bus_wdata_i),
    .commit_o  (commit),
    .viol_o    (viol)
  );

  wrp_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (viol),
    .wr_i   (wr_sel.stat),
    .wbit_i (bus_wdata_i[0]),
    .err_o  (prot_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= CTRL_RST;
    else if (commit) ctrl_q <= bus_wdata_i;
  end

  assign ctrl_o = ctrl_q;

  always_comb begin
    bus_rdata_o = '0;  // command location is write-only
    if (rd_sel.ctrl)      bus_rdata_o = ctrl_q;
    else if (rd_sel.stat) bus_rdata_o = {{PAD_W{1'b0}}, prot_err_o};
  end

endmodule

// File: rtl/wrp_guard_sva.sv
module wrp_guard_sva #(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'hFFC0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFFC1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFFC2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_waddr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [ADDR_W-1:0] bus_raddr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [DATA_W-1:0] ctrl_o,
  input logic              prot_err_o
);

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_CTRL_ONLY_BY_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$stable(ctrl_o)) |-> $past(bus_we_i && bus_waddr_i == CTRL_ADDR)) // R3
    else $error("ctrl changed without a control write");

  AST_ERR_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(prot_err_o)) |->
      $past(bus_we_i && (bus_waddr_i == CTRL_ADDR || bus_waddr_i == CMD_ADDR))) // R4
    else $error("error raised without a guarded write");

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $fell(prot_err_o)) |->
      $past(bus_we_i && bus_waddr_i == STAT_ADDR && !bus_wdata_i[0])) // R9
    else $error("error flag fell without a clearing write");

  AST_STAT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_raddr_i == STAT_ADDR) |-> (bus_rdata_o[DATA_W-1:1] == '0)) // R9
    else $error("status upper bits nonzero");

  AST_CMD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_raddr_i == CMD_ADDR) |-> (bus_rdata_o == '0)) // R10
    else $error("command location readable");

  AST_CTRL_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_raddr_i == CTRL_ADDR) |-> (bus_rdata_o == ctrl_o)) // R10
    else $error("control readback mismatch");

endmodule

bind wrp_guard wrp_guard_sva #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CMD_ADDR  (CMD_ADDR),
  .CTRL_ADDR (CTRL_ADDR),
  .STAT_ADDR (STAT_ADDR)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_waddr_i (bus_waddr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_raddr_i (bus_raddr_i),
  .bus_rdata_o (bus_rdata_o),
  .ctrl_o      (ctrl_o),
  .prot_err_o  (prot_err_o)
);

// File: tb/wrp_guard_test.sv
`timescale 1ns/1ps
module wrp_guard_test;

  localparam logic [15:0] A_CMD  = 16'hFFC0;
  localparam logic [15:0] A_CTRL = 16'hFFC1;
  localparam logic [15:0] A_STAT = 16'hFFC2;
  localparam logic [15:0] A_NONE = 16'h1234;
  localparam logic [7:0]  KEYV   = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] waddr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] raddr = '0;
  logic [7:0]  rdata, ctrl;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wrp_guard uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_waddr_i (waddr),
    .bus_wdata_i (wdata),
    .bus_raddr_i (raddr),
    .bus_rdata_o (rdata),
    .ctrl_o      (ctrl),
    .prot_err_o  (err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    raddr = a;
    #1;
    d = rdata;
  endtask

  task automatic clear_err();
    wr(A_STAT, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 ctrl", ctrl, 8'h00);
    chk("R1 err", {7'b0, err}, 8'h00);
    rd(A_STAT, v); chk("R1 status", v, 8'h00);
    rd(A_CTRL, v); chk("R1 ctrl read", v, 8'h00);
  endtask

  task automatic t_unlock();
    wr(A_CMD, KEYV);
    wr(A_CTRL, 8'h3C); chk("R3 after value", ctrl, 8'h00);
    wr(A_CTRL, 8'hC3); chk("R3 after inverse", ctrl, 8'h00);
    wr(A_CTRL, 8'h3C); chk("R2 update", ctrl, 8'h3C);
    chk("R2 no error", {7'b0, err}, 8'h00);
  endtask

  task automatic t_relock();
    wr(A_CTRL, 8'h55); wr(A_CTRL, 8'hAA); wr(A_CTRL, 8'h55);
    chk("R8 no rekey no change", ctrl, 8'h3C);
    chk("R8 error", {7'b0, err}, 8'h01);
    clear_err();
  endtask

  task automatic t_nokey();
    logic [7:0] v;
    wr(A_CTRL, 8'h77);
    chk("R4 unchanged", ctrl, 8'h3C);
    chk("R4 error", {7'b0, err}, 8'h01);
    wr(A_STAT, 8'hFF);
    rd(A_STAT, v); chk("R9 write 1 keeps flag, upper 0", v, 8'h01);
    wr(A_NONE, 8'h00);
    chk("R9 other write keeps flag", {7'b0, err}, 8'h01);
    wr(A_STAT, 8'hFE);
    rd(A_STAT, v); chk("R9 write 0 clears", v, 8'h00);
  endtask

  task automatic t_badkey();
    wr(A_CMD, 8'h5A);
    chk("R5 bad key error", {7'b0, err}, 8'h01);
    clear_err();
    wr(A_CTRL, 8'h77); wr(A_CTRL, 8'h88); wr(A_CTRL, 8'h77);
    chk("R5 locked after bad key", ctrl, 8'h3C);
    chk("R5 locked error", {7'b0, err}, 8'h01);
    clear_err();
    wr(A_CMD, KEYV); wr(A_CMD, 8'h00);
    wr(A_CTRL, 8'h77); wr(A_CTRL, 8'h88); wr(A_CTRL, 8'h77);
    chk("R5 bad key after good key locks", ctrl, 8'h3C);
    clear_err();
  endtask

  task automatic t_badinv();
    wr(A_CMD, KEYV);
    wr(A_CTRL, 8'h12); wr(A_CTRL, 8'h13);
    chk("R6 error", {7'b0, err}, 8'h01);
    chk("R6 unchanged", ctrl, 8'h3C);
    clear_err();
    wr(A_CTRL, 8'h12);
    chk("R6 locked after break", ctrl, 8'h3C);
    chk("R6 locked error", {7'b0, err}, 8'h01);
    clear_err();
  endtask

  task automatic t_badrepeat();
    wr(A_CMD, KEYV);
    wr(A_CTRL, 8'h12); wr(A_CTRL, 8'hED);
    chk("R7 no error yet", {7'b0, err}, 8'h00);
    wr(A_CTRL, 8'h13);
    chk("R7 unchanged", ctrl, 8'h3C);
    chk("R7 error", {7'b0, err}, 8'h01);
    clear_err();
  endtask

  task automatic t_interleave();
    wr(A_CMD, KEYV);
    wr(A_CTRL, 8'h9A);
    wr(A_STAT, 8'h00);
    wr(A_NONE, 8'hFF);
    wr(A_CTRL, 8'h65);
    wr(A_STAT, 8'h01);
    wr(A_CTRL, 8'h9A);
    chk("R11 update through neutral writes", ctrl, 8'h9A);
    chk("R11 no error", {7'b0, err}, 8'h00);
  endtask

  task automatic t_restart();
    wr(A_CMD, KEYV);
    wr(A_CTRL, 8'h11);
    wr(A_CMD, KEYV);
    wr(A_CTRL, 8'h22); wr(A_CTRL, 8'hDD);
    chk("R12 not yet", ctrl, 8'h9A);
    wr(A_CTRL, 8'h22);
    chk("R12 restart update", ctrl, 8'h22);
    chk("R12 no error", {7'b0, err}, 8'h00);
  endtask

  task automatic t_reads();
    logic [7:0] v;
    rd(A_CMD, v);  chk("R10 cmd reads zero", v, 8'h00);
    rd(A_NONE, v); chk("R10 undecoded reads zero", v, 8'h00);
    rd(A_CTRL, v); chk("R10 ctrl readback", v, 8'h22);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_relock();
    t_nokey();
    t_badkey();
    t_badinv();
    t_badrepeat();
    t_interleave();
    t_restart();
    t_reads();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule